// File: doc/BRIEF.md
# Wavefront Lane Integer and Bit-Manipulation ALU

This block is the integer datapath of a single lane in a 64-lane wavefront vector unit. Each issued operation carries a 6-bit opcode, two 32-bit operands, the lane's own index and the 64-bit wave mask shared by all lanes. The block returns a 32-bit result and an updated copy of the wave mask one clock later, together with a valid strobe.

The operations are bit-run mask generation, population count with accumulate, rank counting against the lanes below the current one (low or high 32-lane half), addition and both subtraction orders with the carry or borrow written to this lane's own mask bit, selection between the operands by this lane's mask bit, and bitwise XOR. A carry is never held in a private flag. It lands in the shared wave mask at the position given by the lane index, so the 64 lanes together build a complete carry vector. No other mask bit can change.

Top module: `lane_int_alu`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, `result` and `wave_mask_out` become zero.
- R2: An operation issued with `in_valid` high at edge N appears at edge N+1 with `out_valid` high. When `in_valid` is low, `out_valid` falls and `result` and `wave_mask_out` hold their values.
- R3: Opcode 0x1e returns a word whose bits are set exactly at positions p with `src_b[4:0]` <= p < `src_b[4:0]` + `src_a[4:0]` and p <= 31.
- R4: Opcode 0x1d returns `src_a ^ src_b`.
- R5: Opcode 0x22 returns `src_b` plus the number of set bits in `src_a`, modulo 2^32.
- R6: Opcode 0x23 returns `src_b` plus the number of bits i of `src_a` with i < 32 and i < `lane_idx`. For lane 32 or above, every bit of `src_a` counts.
- R7: Opcode 0x24 returns `src_b` plus the number of bits i of `src_a` with i + 32 < `lane_idx`. For a lane below 32 the result equals `src_b`.
- R8: Opcode 0x25 returns the low 32 bits of `src_a + src_b` and writes the carry out to bit `lane_idx` of the mask.
- R9: Opcode 0x26 returns `src_a - src_b` and opcode 0x27 returns `src_b - src_a`, both modulo 2^32. Each writes a borrow (1 when the unsigned minuend is smaller than the subtrahend) to bit `lane_idx` of the mask.
- R10: Every mask bit other than bit `lane_idx` is copied unchanged from `wave_mask_in` to `wave_mask_out`. Opcodes other than 0x25, 0x26 and 0x27 leave the whole mask unchanged.
- R11: Opcode 0x00 returns `src_b` when `wave_mask_in[lane_idx]` is 1 and `src_a` when it is 0.
- R12: Any opcode not listed in R3 to R11 returns zero and leaves the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation issued this cycle |
| opcode | input | 6 | Operation code |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Second operand |
| lane_idx | input | 6 | Index of this lane in the wavefront |
| wave_mask_in | input | 64 | Shared wave condition and carry mask |
| out_valid | output | 1 | Result registered this cycle |
| result | output | 32 | Operation result |
| wave_mask_out | output | 64 | Wave mask after this lane's update |

## Verification
The bit-run generator is swept over all 1024 length and position pairs, which separates masking of the shift amounts from clipping at bit 31. The rank counts run on every one of the 64 lane indices with all-ones and sparse operands, so an off-by-one at the lane boundary or at the 32-lane half is visible. Add and both subtractions run on every lane against an all-ones and an all-zero mask, with operands that produce and that avoid a carry or borrow, so a write to the wrong bit or a lost clear stands out. Selection runs on every lane against an alternating mask, and all 55 undefined opcodes are issued against a non-trivial mask.

// File: rtl/lane_alu_pkg.sv
package lane_alu_pkg;

    localparam int DATA_W = 32;
    localparam int LANES  = 2 * DATA_W;
    localparam int LANE_W = $clog2(LANES);
    localparam int OP_W   = 6;
    localparam int SHAMT_W = $clog2(DATA_W);
    localparam int CNT_W  = $clog2(DATA_W) + 1;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [LANES-1:0]  wmask_t;
    typedef logic [LANE_W-1:0] lane_t;

    typedef enum logic [OP_W-1:0] {
        OP_SELECT  = 6'h00,
        OP_XOR     = 6'h1d,
        OP_FIELD   = 6'h1e,
        OP_POPADD  = 6'h22,
        OP_RANK_LO = 6'h23,
        OP_RANK_HI = 6'h24,
        OP_ADD     = 6'h25,
        OP_SUB     = 6'h26,
        OP_RSUB    = 6'h27
    } op_e;

    typedef struct packed {
        word_t value;
        logic  carry;
        logic  hit;
    } arith_res_t;

    function automatic logic [CNT_W-1:0] pop_count(input word_t v);
        logic [CNT_W-1:0] c;
        c = '0;
        for (int i = 0; i < DATA_W; i++) begin
            c = c + CNT_W'(v[i]);
        end
        return c;
    endfunction

    function automatic logic op_known(input logic [OP_W-1:0] op);
        case (op)
            OP_SELECT, OP_XOR, OP_FIELD, OP_POPADD, OP_RANK_LO,
            OP_RANK_HI, OP_ADD, OP_SUB, OP_RSUB: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/lane_bitops.sv
module lane_bitops
    import lane_alu_pkg::*;
(
    input  logic [OP_W-1:0] op,
    input  word_t           a,
    input  word_t           b,
    input  lane_t           lane,
    output word_t           value,
    output logic            hit
);
    // One bit per wave lane: set when that lane sits strictly below this one.
    wmask_t below;

    for (genvar g = 0; g < LANES; g++) begin : g_below
        assign below[g] = (LANE_W'(g) < lane);
    end

    logic [SHAMT_W-1:0] run_len;
    logic [SHAMT_W-1:0] run_pos;
    word_t              run_word;

    assign run_len  = a[SHAMT_W-1:0];
    assign run_pos  = b[SHAMT_W-1:0];
    assign run_word = ((word_t'(1) << run_len) - word_t'(1)) << run_pos;

    always_comb begin
        value = '0;
        hit   = 1'b1;
        case (op)
            OP_XOR:     value = a ^ b;
            OP_FIELD:   value = run_word;
            OP_POPADD:  value = b + word_t'(pop_count(a));
            OP_RANK_LO: value = b + word_t'(pop_count(a & below[DATA_W-1:0]));
            OP_RANK_HI: value = b + word_t'(pop_count(a & below[LANES-1:DATA_W]));
            default:    hit   = 1'b0;
        endcase
    end

endmodule

// File: rtl/lane_arith.sv
module lane_arith
    import lane_alu_pkg::*;
(
    input  logic [OP_W-1:0] op,
    input  word_t           a,
    input  word_t           b,
    output arith_res_t      res
);
    logic [DATA_W:0] wide;

    always_comb begin
        wide    = '0;
        res.hit = 1'b1;
        case (op)
            OP_ADD:  wide = {1'b0, a} + {1'b0, b};
            OP_SUB:  wide = {1'b0, a} - {1'b0, b};
            OP_RSUB: wide = {1'b0, b} - {1'b0, a};
            default: res.hit = 1'b0;
        endcase
        // Bit DATA_W is the carry for addition and the borrow for subtraction.
        res.value = wide[DATA_W-1:0];
        res.carry = wide[DATA_W];
    end

endmodule

// File: rtl/lane_mask_merge.sv
module lane_mask_merge
    import lane_alu_pkg::*;
(
    input  wmask_t mask_in,
    input  lane_t  lane,
    input  logic   wr_en,
    input  logic   wr_bit,
    output wmask_t mask_out,
    output logic   own_bit
);
    for (genvar g = 0; g < LANES; g++) begin : g_merge
        assign mask_out[g] = (wr_en && (lane == LANE_W'(g))) ? wr_bit : mask_in[g];
    end

    assign own_bit = mask_in[lane];

endmodule

// File: rtl/lane_int_alu.sv
module lane_int_alu
    import lane_alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   opcode,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [LANE_W-1:0] lane_idx,
    input  logic [LANES-1:0]  wave_mask_in,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic [LANES-1:0]  wave_mask_out
);
    word_t      bit_value;
    logic       bit_hit;
    arith_res_t arith;
    wmask_t     mask_next;
    logic       own_bit;
    word_t      value_next;

    lane_bitops u_bitops (
        .op    (opcode),
        .a     (src_a),
        .b     (src_b),
        .lane  (lane_idx),
        .value (bit_value),
        .hit   (bit_hit)
    );

    lane_arith u_arith (
        .op  (opcode),
        .a   (src_a),
        .b   (src_b),
        .res (arith)
    );

    lane_mask_merge u_merge (
        .mask_in  (wave_mask_in),
        .lane     (lane_idx),
        .wr_en    (arith.hit),
        .wr_bit   (arith.carry),
        .mask_out (mask_next),
        .own_bit  (own_bit)
    );

    always_comb begin
        value_next = '0;
        if (arith.hit) begin
            value_next = arith.value;
        end else if (bit_hit) begin
            value_next = bit_value;
        end else if (opcode == OP_SELECT) begin
            value_next = own_bit ? src_b : src_a;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid     <= 1'b0;
            result        <= '0;
            wave_mask_out <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result        <= value_next;
                wave_mask_out <= mask_next;
            end
        end
    end

    // Output strobe trails the issue strobe by exactly one edge.
    assert_valid_latency_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_valid == $past(in_valid)));

    // Outputs hold while nothing is issued.
    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(in_valid)) |-> ($stable(result) && $stable(wave_mask_out)));

    // Only this lane's mask bit may differ from the issued mask.
    assert_mask_isolation_R10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !$past(rst)) |->
        (((wave_mask_out ^ $past(wave_mask_in)) & ~(wmask_t'(1) << $past(lane_idx))) == '0));

    // Select follows this lane's condition bit.
    assert_select_bit_R11: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid) && ($past(opcode) == OP_SELECT)) |->
        (result == ($past(wave_mask_in[lane_idx]) ? $past(src_b) : $past(src_a))));

    // High-half rank in a low-half lane reduces to the accumulator.
    assert_rank_hi_low_lane_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid) && ($past(opcode) == OP_RANK_HI) &&
         ($past(lane_idx) < LANE_W'(DATA_W))) |-> (result == $past(src_b)));

    // Undefined opcodes produce zero and pass the mask through.
    assert_unknown_op_R12: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid) && !op_known($past(opcode))) |->
        ((result == '0) && (wave_mask_out == $past(wave_mask_in))));

    // Non-arithmetic opcodes leave the full mask intact.
    assert_mask_untouched_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid) && ($past(opcode) != OP_ADD) &&
         ($past(opcode) != OP_SUB) && ($past(opcode) != OP_RSUB)) |->
        (wave_mask_out == $past(wave_mask_in)));

endmodule

// File: tb/test_lane_int_alu.sv
`timescale 1ns/1ps
module test_lane_int_alu;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [5:0]  opcode = '0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [5:0]  lane_idx = '0;
    logic [63:0] wave_mask_in = '0;
    logic        out_valid;
    logic [31:0] result;
    logic [63:0] wave_mask_out;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    lane_int_alu i_lane_int_alu (
        .clk           (clk),
        .rst           (rst),
        .in_valid      (in_valid),
        .opcode        (opcode),
        .src_a         (src_a),
        .src_b         (src_b),
        .lane_idx      (lane_idx),
        .wave_mask_in  (wave_mask_in),
        .out_valid     (out_valid),
        .result        (result),
        .wave_mask_out (wave_mask_out)
    );

    task automatic model(input logic [5:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [5:0] ln, input logic [63:0] m,
                         output logic [31:0] r, output logic [63:0] mo);
        logic [63:0] wide;
        int len;
        int pos;
        r  = '0;
        mo = m;
        len = int'(a[4:0]);
        pos = int'(b[4:0]);
        case (op)
            6'h00: r = m[ln] ? b : a;
            6'h1d: r = a ^ b;
            6'h1e: for (int i = 0; i < 32; i++) if (i >= pos && i < pos + len) r[i] = 1'b1;
            6'h22: begin r = b; for (int i = 0; i < 32; i++) if (a[i]) r = r + 1; end
            6'h23: begin r = b; for (int i = 0; i < 32; i++) if (a[i] && i < int'(ln)) r = r + 1; end
            6'h24: begin r = b; for (int i = 0; i < 32; i++) if (a[i] && i + 32 < int'(ln)) r = r + 1; end
            6'h25: begin wide = 64'(a) + 64'(b); r = wide[31:0]; mo[ln] = (wide > 64'hFFFF_FFFF); end
            6'h26: begin r = a - b; mo[ln] = (a < b); end
            6'h27: begin r = b - a; mo[ln] = (b < a); end
            default: begin r = '0; mo = m; end
        endcase
    endtask

    task automatic apply(input logic [5:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [5:0] ln, input logic [63:0] m, input string req);
        logic [31:0] er;
        logic [63:0] em;
        @(negedge clk);
        in_valid = 1'b1; opcode = op; src_a = a; src_b = b; lane_idx = ln; wave_mask_in = m;
        @(negedge clk);
        in_valid = 1'b0;
        model(op, a, b, ln, m, er, em);
        checks++;
        if (!out_valid || result !== er || wave_mask_out !== em) begin
            fails++;
            $display("FAIL %s op=%h lane=%0d: valid=%b result=%h mask=%h expected valid=1 result=%h mask=%h",
                     req, op, ln, out_valid, result, wave_mask_out, er, em);
        end
    endtask

    task automatic expect_idle(input logic [31:0] er, input logic [63:0] em);
        checks++;
        if (out_valid !== 1'b0 || result !== er || wave_mask_out !== em) begin
            fails++;
            $display("FAIL R2 idle: valid=%b result=%h mask=%h expected valid=0 result=%h mask=%h",
                     out_valid, result, wave_mask_out, er, em);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : stim
        logic [63:0] pat;
        pat = 64'hF0F0_5A5A_3C3C_9696;
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (out_valid !== 1'b0 || result !== '0 || wave_mask_out !== '0) begin
            fails++;
            $display("FAIL R1 reset: valid=%b result=%h mask=%h expected 0/0/0", out_valid, result, wave_mask_out);
        end
        @(negedge clk);
        rst = 1'b0;

        // R3: all length/position pairs
        for (int n = 0; n < 32; n++)
            for (int s = 0; s < 32; s++)
                apply(6'h1e, {27'h5A5A5A5, 5'(n)}, {27'h3C3C3C3, 5'(s)}, 6'(n + s), pat, "R3");

        // R2: hold after an idle cycle
        @(negedge clk);
        expect_idle(32'h0000_0000 | (((32'd1 << 31) - 1) << 31), pat);

        // R4, R5
        apply(6'h1d, 32'hDEAD_BEEF, 32'h1234_5678, 6'd7, pat, "R4");
        apply(6'h1d, 32'hFFFF_FFFF, 32'h0F0F_0F0F, 6'd40, ~pat, "R4");
        apply(6'h22, 32'hFFFF_FFFF, 32'd10, 6'd3, pat, "R5");
        apply(6'h22, 32'h0000_0000, 32'd77, 6'd3, pat, "R5");
        apply(6'h22, 32'h8000_0001, 32'hFFFF_FFFF, 6'd63, pat, "R5");

        // R6, R7: every lane, dense and sparse operands
        for (int l = 0; l < 64; l++) begin
            apply(6'h23, 32'hFFFF_FFFF, 32'd5, 6'(l), pat, "R6");
            apply(6'h23, 32'h9249_2492, 32'd0, 6'(l), ~pat, "R6");
            apply(6'h24, 32'hFFFF_FFFF, 32'd9, 6'(l), pat, "R7");
            apply(6'h24, 32'h2492_4924, 32'd1, 6'(l), ~pat, "R7");
        end

        // R8, R9, R10: carry/borrow into every lane's bit
        for (int l = 0; l < 64; l++) begin
            apply(6'h25, 32'hFFFF_FFFF, 32'd1, 6'(l), 64'd0, "R8");
            apply(6'h25, 32'd1, 32'd2, 6'(l), '1, "R8");
            apply(6'h25, 32'h8000_0000, 32'h8000_0000, 6'(l), pat, "R8");
            apply(6'h26, 32'd3, 32'd5, 6'(l), 64'd0, "R9");
            apply(6'h26, 32'd5, 32'd5, 6'(l), '1, "R9");
            apply(6'h27, 32'd5, 32'd3, 6'(l), 64'd0, "R9");
            apply(6'h27, 32'd3, 32'hFFFF_FFFF, 6'(l), '1, "R9");
        end

        // R11: select against an alternating mask on every lane
        for (int l = 0; l < 64; l++) begin
            apply(6'h00, 32'hAAAA_0000, 32'h0000_5555, 6'(l), 64'h5555_5555_5555_5555, "R11");
            apply(6'h00, 32'h1111_1111, 32'h2222_2222, 6'(l), pat, "R11");
        end

        // R12, R10: every undefined opcode
        for (int o = 0; o < 64; o++) begin
            if (!(o == 'h00 || o == 'h1d || o == 'h1e || (o >= 'h22 && o <= 'h27)))
                apply(6'(o), 32'hCAFE_F00D, 32'h0BAD_0BAD, 6'(o), pat, "R12");
        end

        // R2: idle after a sequence, outputs hold
        apply(6'h25, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 6'd12, 64'd0, "R2");
        @(negedge clk);
        expect_idle(32'hFFFF_FFFE, 64'd1 << 12);

        // R1: reset during operation
        rst = 1'b1;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || result !== '0 || wave_mask_out !== '0) begin
            fails++;
            $display("FAIL R1 re-reset: valid=%b result=%h mask=%h expected 0/0/0", out_valid, result, wave_mask_out);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule